// File: doc/BRIEF.md
# Line Sensor Readout Timing Controller

This block sits on the host side of a 32-pixel linear light sensor. It makes the sensor's clock and line-start inputs from a fast system clock. It also tells a downstream sampler when each pixel voltage on the analogue output has settled, and which pixel that voltage belongs to. The sensor clock runs all the time. Its half period comes from a configuration input, and that value is raised to a floor, so the sensor clock never runs faster than 5 MHz and always leaves room for the settling delay.

A line starts when the start strobe is sampled high on a rising sensor-clock edge. That same edge puts pixel 0 on the output. Each later rising edge moves on to the next pixel, and after 32 edges the line is done. On the sensor, readout and exposure overlap, so every line start also begins the next exposure. For that reason the controller waits for a programmed integration interval between starts. It never restarts a line that is still being read unless an abort is requested. An optional shutter output holds integration frozen for the early part of each line period, which shortens the effective exposure.

With a 250 MHz system clock, the guard times come out as follows:
- setup and hold: 13 cycles each, about 52 ns
- settling: 50 cycles, 200 ns
- half-period floor: 26 cycles

Top module: `linesens_ctrl`

## Requirements
- R1: Sensor-clock timing:
  - The sensor clock period is 2*max(cfg_half_i, 26) system cycles.
  - It is high for the first half of the period and low for the second half.
  - A new cfg_half_i takes effect only at a period boundary.
- R2: The start strobe goes high exactly 13 system cycles before the rising sensor-clock edge that samples it.
- R3: The start strobe stays high for exactly 13 system cycles starting at that edge, then returns low.
- R4: Pixel strobes for one line:
  - Each line produces exactly 32 pixel strobes.
  - The strobes carry indices 0 to 31 in order, one per rising sensor-clock edge.
  - Index 0 belongs to the edge that sampled the start strobe.
- R5: A pixel strobe is a one-cycle pulse of px_vld_o. It comes exactly 50 system cycles after the rising sensor-clock edge it belongs to.
- R6: line_done_o pulses for one cycle, exactly one cycle after the strobe with index 31. A line cut short by an abort gives no line_done_o.
- R7: While enable is held high, two consecutive sampling edges of the start strobe are separated by P*max(32, ceil((cfg_integ_i+14)/P)) system cycles, where P is the sensor-clock period.
- R8: Abort behaviour:
  - No start is issued while a line still has sensor-clock edges to receive, unless abort_i was pulsed.
  - An abort during readout restarts the line, with its sampling edge no more than two sensor-clock periods later.
  - An abort while no line is being read causes no start.
- R9: Shutter behaviour:
  - When 0 < cfg_expo_i < cfg_integ_i, dis_o is high from the start-sampling edge for exactly cfg_integ_i − cfg_expo_i cycles, then low.
  - Otherwise dis_o stays low.
- R10: Reset and enable:
  - After reset, si_o, px_vld_o, line_done_o and dis_o are low.
  - While en_i is low, no new line starts, but a line already in progress completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Allows new line starts |
| abort_i | input | 1 | One-cycle request to restart the current line |
| cfg_half_i | input | HALF_W | Requested sensor-clock half period, in system cycles |
| cfg_integ_i | input | INTEG_W | Minimum spacing of line starts, in system cycles |
| cfg_expo_i | input | INTEG_W | Exposure window at the end of the line period; 0 disables the shutter |
| sclk_o | output | 1 | Sensor clock |
| si_o | output | 1 | Sensor line-start strobe |
| dis_o | output | 1 | Shutter: high freezes integration |
| px_vld_o | output | 1 | Pixel sample strobe |
| px_idx_o | output | $clog2(NPIX) | Index of the pixel being strobed |
| line_done_o | output | 1 | Pulse after the last pixel of a complete line |

## Verification
A wrong phase count shows up within one sensor-clock period, in three ways:
- the rising edges are not spaced by the clamped period;
- the start strobe edges move off their 13-cycle guard distances;
- the pixel strobes stop arriving 50 cycles after an edge.

A corrupted pixel counter or readout flag shows up in the very next strobe, as a wrong index. Lost state can also show as a 33rd strobe, a missing or misplaced line_done_o, or a start sampled while pixels are still pending. A bad integration timer shifts the spacing of the next start and the point where the shutter falls, so the error appears within one line period.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lsc_clkgen.sv
// Free-running sensor clock with clamped half period and phase markers.
module lsc_clkgen #(
    parameter int HALF_W   = 8,
    parameter int MIN_HALF = 26,
    parameter int SETUP_C  = 13,
    parameter int HOLD_C   = 13,
    parameter int SETTLE_C = 50
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [HALF_W-1:0] cfg_half_i,
    output logic              sclk_o,
    output logic [HALF_W:0]   cnt_o,
    output logic              wrap_o,
    output logic              decide_o,
    output logic              hold_end_o,
    output logic              prestrobe_o
);
    localparam int CNT_W = HALF_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [HALF_W-1:0] half;
        logic              sclk;
    } clk_st_t;

    clk_st_t q, d;
    logic [HALF_W-1:0] eff_half;
    logic [CNT_W-1:0]  per_last;

    always_comb begin
        eff_half = (cfg_half_i < HALF_W'(MIN_HALF)) ? HALF_W'(MIN_HALF) : cfg_half_i;
        per_last = {q.half, 1'b0} - CNT_W'(1);
        wrap_o   = (q.cnt == per_last);
        d        = q;
        d.cnt    = wrap_o ? '0 : q.cnt + CNT_W'(1);
        if (wrap_o) begin
            d.half = eff_half;
        end
        d.sclk      = (d.cnt < {1'b0, q.half});
        decide_o    = (q.cnt == per_last - CNT_W'(SETUP_C));
        hold_end_o  = (q.cnt == CNT_W'(HOLD_C - 1));
        prestrobe_o = (q.cnt == CNT_W'(SETTLE_C - 1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.cnt  <= CNT_W'(MIN_HALF);
            q.half <= HALF_W'(MIN_HALF);
            q.sclk <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sclk_o = q.sclk;
    assign cnt_o  = q.cnt;

    // R1
    period_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |-> (q.cnt >= CNT_W'(2 * MIN_HALF - 1)));

    // R1
    rise_at_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> $rose(sclk_o));
endmodule

// File: rtl/lsc_seq.sv
// Start strobe placement, integration timer and shutter window.
module lsc_seq #(
    parameter int INTEG_W = 20
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic               abort_i,
    input  logic [INTEG_W-1:0] cfg_integ_i,
    input  logic [INTEG_W-1:0] cfg_expo_i,
    input  logic               sclk_i,
    input  logic               wrap_i,
    input  logic               decide_i,
    input  logic               hold_end_i,
    input  logic               busy_i,
    output logic               si_o,
    output logic               srise_o,
    output logic               dis_o
);
    typedef struct packed {
        logic               si;
        logic               abt;
        logic               seen;
        logic               dis;
        logic [INTEG_W-1:0] tmr;
    } seq_st_t;

    seq_st_t q, d;
    logic               go;
    logic               expo_on;
    logic [INTEG_W-1:0] thr;

    always_comb begin
        d       = q;
        srise_o = wrap_i && q.si;
        go      = decide_i && ((q.abt && busy_i) ||
                               (en_i && !busy_i && (q.tmr >= cfg_integ_i)));
        d.abt   = decide_i ? abort_i : (q.abt | abort_i);
        if (go) begin
            d.si = 1'b1;
        end else if (hold_end_i) begin
            d.si = 1'b0;
        end
        if (srise_o) begin
            d.tmr = '0;
        end else if (q.tmr != '1) begin
            d.tmr = q.tmr + INTEG_W'(1);
        end
        d.seen  = q.seen | srise_o;
        expo_on = (cfg_expo_i != '0) && (cfg_expo_i < cfg_integ_i);
        thr     = cfg_integ_i - cfg_expo_i;
        d.dis   = d.seen && expo_on && (d.tmr < thr);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.si   <= 1'b0;
            q.abt  <= 1'b0;
            q.seen <= 1'b0;
            q.dis  <= 1'b0;
            q.tmr  <= '1;
        end else begin
            q <= d;
        end
    end

    assign si_o  = q.si;
    assign dis_o = q.dis;

    // R2
    si_rise_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.si) |-> !sclk_i);

    // R3
    si_fall_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(q.si) |-> sclk_i);

    // R8
    no_midline_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.si) |-> $past(!busy_i || q.abt));
endmodule

// File: rtl/lsc_rdout.sv
// Pixel sequencing: strobes, indices and line completion.
module lsc_rdout #(
    parameter int NPIX     = 32,
    parameter int CNT_W    = 9,
    parameter int SETTLE_C = 50
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    wrap_i,
    input  logic                    srise_i,
    input  logic                    prestrobe_i,
    input  logic [CNT_W-1:0]        cnt_i,
    output logic                    busy_o,
    output logic                    vld_o,
    output logic [$clog2(NPIX)-1:0] idx_o,
    output logic                    done_o
);
    localparam int IDX_W = $clog2(NPIX);
    localparam int RC_W  = $clog2(NPIX + 1);

    typedef struct packed {
        logic             act;
        logic [RC_W-1:0]  rc;
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic             done;
    } rd_st_t;

    rd_st_t q, d;

    always_comb begin
        d      = q;
        d.vld  = 1'b0;
        d.done = q.vld && (q.idx == IDX_W'(NPIX - 1));
        if (srise_i) begin
            d.act = 1'b1;
            d.rc  = RC_W'(1);
        end else if (wrap_i && q.act && (q.rc != RC_W'(NPIX))) begin
            d.rc = q.rc + RC_W'(1);
        end
        if (prestrobe_i && q.act) begin
            d.vld = 1'b1;
            d.idx = IDX_W'(q.rc - RC_W'(1));
            if (q.rc == RC_W'(NPIX)) begin
                d.act = 1'b0;
            end
        end
        busy_o = q.act && (q.rc != RC_W'(NPIX));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign vld_o  = q.vld;
    assign idx_o  = q.idx;
    assign done_o = q.done;

    // R5
    strobe_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.vld |-> (cnt_i == CNT_W'(SETTLE_C)));

    // R6
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.done |=> !q.done);

    // R4
    strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.vld |=> !q.vld);
endmodule

// File: rtl/linesens_ctrl.sv
module linesens_ctrl
    import lsc_pkg::*;
#(
    parameter int SYS_MHZ      = 250,
    parameter int SCLK_MAX_KHZ = 5000,
    parameter int SETUP_NS     = 50,
    parameter int HOLD_NS      = 50,
    parameter int SETTLE_NS    = 200,
    parameter int NPIX         = 32,
    parameter int HALF_W       = 8,
    parameter int INTEG_W      = 20
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    en_i,
    input  logic                    abort_i,
    input  logic [HALF_W-1:0]       cfg_half_i,
    input  logic [INTEG_W-1:0]      cfg_integ_i,
    input  logic [INTEG_W-1:0]      cfg_expo_i,
    output logic                    sclk_o,
    output logic                    si_o,
    output logic                    dis_o,
    output logic                    px_vld_o,
    output logic [$clog2(NPIX)-1:0] px_idx_o,
    output logic                    line_done_o
);
    localparam int SETUP_C  = ceil_div(SETUP_NS * SYS_MHZ, 1000);
    localparam int HOLD_C   = ceil_div(HOLD_NS * SYS_MHZ, 1000);
    localparam int SETTLE_C = ceil_div(SETTLE_NS * SYS_MHZ, 1000);
    localparam int FREQ_HALF = ceil_div(SYS_MHZ * 1000, 2 * SCLK_MAX_KHZ);
    localparam int MIN_HALF = imax(imax(FREQ_HALF, ceil_div(SETTLE_C + 1, 2)),
                                   imax(SETUP_C + 1, HOLD_C + 1));
    localparam int CNT_W    = HALF_W + 1;

    logic [CNT_W-1:0] cnt;
    logic wrap, decide, hold_end, prestrobe, busy, srise, sclk;

    lsc_clkgen #(
        .HALF_W(HALF_W), .MIN_HALF(MIN_HALF), .SETUP_C(SETUP_C),
        .HOLD_C(HOLD_C), .SETTLE_C(SETTLE_C)
    ) u_clk (
        .clk_i(clk_i), .rst_ni(rst_ni), .cfg_half_i(cfg_half_i),
        .sclk_o(sclk), .cnt_o(cnt), .wrap_o(wrap), .decide_o(decide),
        .hold_end_o(hold_end), .prestrobe_o(prestrobe)
    );

    lsc_seq #(.INTEG_W(INTEG_W)) u_seq (
        .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .abort_i(abort_i),
        .cfg_integ_i(cfg_integ_i), .cfg_expo_i(cfg_expo_i), .sclk_i(sclk),
        .wrap_i(wrap), .decide_i(decide), .hold_end_i(hold_end), .busy_i(busy),
        .si_o(si_o), .srise_o(srise), .dis_o(dis_o)
    );

    lsc_rdout #(.NPIX(NPIX), .CNT_W(CNT_W), .SETTLE_C(SETTLE_C)) u_rd (
        .clk_i(clk_i), .rst_ni(rst_ni), .wrap_i(wrap), .srise_i(srise),
        .prestrobe_i(prestrobe), .cnt_i(cnt), .busy_o(busy),
        .vld_o(px_vld_o), .idx_o(px_idx_o), .done_o(line_done_o)
    );

    assign sclk_o = sclk;
endmodule

// File: tb/sim_linesens_ctrl.sv
module sim_linesens_ctrl;
    localparam int SETUP_CY  = (50 * 250 + 999) / 1000;
    localparam int HOLD_CY   = (50 * 250 + 999) / 1000;
    localparam int SETTLE_CY = (200 * 250 + 999) / 1000;
    localparam int MINH      = 26;

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, abort = 1'b0;
    logic [7:0]  half = '0;
    logic [19:0] integ = '0, expo = '0;
    logic sclk, si, dis, vld, done;
    logic [4:0] idx;

    always #2 clk = ~clk;

    linesens_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .abort_i(abort),
        .cfg_half_i(half), .cfg_integ_i(integ), .cfg_expo_i(expo),
        .sclk_o(sclk), .si_o(si), .dis_o(dis), .px_vld_o(vld),
        .px_idx_o(idx), .line_done_o(done)
    );

    int nchk = 0, nfail = 0, cyc = 0, wd = 0;
    int exp_q[$];
    int exp_per = 2 * MINH, exp_half = MINH, exp_gap = 0, per_skip = 2;
    bit gap_arm = 0, expo_on_tb = 0, abort_exp = 0, restarted = 0;
    int t_rise = -1, t_srise = -1, t_si_up = -1, t_abort = 0, done_due = -1;
    int nstarts = 0, nlines = 0, last_idx = -1, lines_at_abort = 0;
    logic sclk_p = 0, si_p = 0, dis_p = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    function automatic int gap_of(input int p, input int itg);
        int n;
        n = (itg + SETUP_CY + 1 + p - 1) / p;
        if (n < 32) n = 32;
        return p * n;
    endfunction

    // driver side: expected pixel items for one line
    task automatic expect_line();
        for (int i = 0; i < 32; i++) exp_q.push_back(i);
    endtask

    task automatic config_run(input int h, input int itg, input int ex);
        int he;
        half = 8'(h); integ = 20'(itg); expo = 20'(ex);
        he = (h < MINH) ? MINH : h;
        exp_half = he; exp_per = 2 * he;
        exp_gap = gap_of(exp_per, itg);
        expo_on_tb = (ex != 0) && (ex < itg);
        gap_arm = 0; per_skip = 2;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        wd++;
        if (wd > 150000) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
            finish_run();
        end
        if (rst_n) begin
            cyc++;
            if (si && !si_p) t_si_up = cyc;
            if (!si && si_p) chk(cyc - t_srise == HOLD_CY, "R3", cyc - t_srise, HOLD_CY);
            if (!sclk && sclk_p && per_skip == 0)
                chk(cyc - t_rise == exp_half, "R1 high", cyc - t_rise, exp_half);
            if (sclk && !sclk_p) begin
                if (per_skip > 0) per_skip--;
                else chk(cyc - t_rise == exp_per, "R1 period", cyc - t_rise, exp_per);
                t_rise = cyc;
                if (si) begin
                    nstarts++;
                    chk(cyc - t_si_up == SETUP_CY, "R2", cyc - t_si_up, SETUP_CY);
                    if (gap_arm) chk(cyc - t_srise == exp_gap, "R7", cyc - t_srise, exp_gap);
                    chk(dis == expo_on_tb, "R9 start", int'(dis), int'(expo_on_tb));
                    if (abort_exp) begin
                        chk(cyc - t_abort <= 2 * exp_per, "R8 restart", cyc - t_abort, 2 * exp_per);
                        chk(nlines == lines_at_abort, "R6 aborted", nlines, lines_at_abort);
                        chk(exp_q.size() > 0, "R8 leftover", exp_q.size(), 1);
                        exp_q.delete();
                        abort_exp = 0; restarted = 1;
                    end else begin
                        chk(exp_q.size() == 0, "R8 midline", exp_q.size(), 0);
                        exp_q.delete();
                    end
                    expect_line();
                    t_srise = cyc; gap_arm = 1;
                end
            end
            if (vld) begin
                chk(cyc - t_rise == SETTLE_CY, "R5", cyc - t_rise, SETTLE_CY);
                if (exp_q.size() == 0) chk(0, "R4 extra", int'(idx), -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(idx) == e, "R4", int'(idx), e);
                end
                last_idx = int'(idx);
                if (idx == 5'd31) done_due = cyc + 1;
            end
            if (done) begin
                chk(cyc == done_due, "R6", cyc, done_due);
                nlines++;
            end
            if (dis && !dis_p && !expo_on_tb) chk(0, "R9 off", 1, 0);
            if (!dis && dis_p && expo_on_tb)
                chk(cyc - t_srise == int'(integ - expo), "R9 window", cyc - t_srise, int'(integ - expo));
            sclk_p = sclk; si_p = si; dis_p = dis;
        end
    end

    initial begin
        int base;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!si && !vld && !done && !dis, "R10 reset", int'({si, vld, done, dis}), 0);
        repeat (400) @(posedge clk);
        chk(nstarts == 0, "R10 idle", nstarts, 0);
        #1 abort = 1'b1;
        @(posedge clk); #1 abort = 1'b0;
        repeat (400) @(posedge clk);
        chk(nstarts == 0, "R8 idle abort", nstarts, 0);

        // clamp of a too-small half period, short interval, no shutter
        config_run(3, 100, 0);
        #1 en = 1'b1;
        wait (nlines >= 3);
        @(posedge clk); #1 en = 1'b0;
        repeat (2500) @(posedge clk);
        chk(exp_q.size() == 0, "R10 finish", exp_q.size(), 0);
        base = nstarts;
        repeat (2000) @(posedge clk);
        chk(nstarts == base, "R10 hold", nstarts, base);

        // slow clock, long interval, shutter window
        config_run(40, 3000, 1000);
        base = nlines;
        #1 en = 1'b1;
        wait (nlines >= base + 3);
        @(posedge clk); #1 en = 1'b0;
        repeat (3500) @(posedge clk);

        // abort in mid readout
        config_run(30, 100, 0);
        base = nlines;
        #1 en = 1'b1;
        wait (nlines >= base + 1);
        wait (last_idx == 5);
        @(posedge clk);
        #1 abort = 1'b1;
        abort_exp = 1; gap_arm = 0; t_abort = cyc; lines_at_abort = nlines;
        @(posedge clk); #1 abort = 1'b0;
        wait (nlines >= lines_at_abort + 2);
        chk(restarted, "R8 abort", int'(restarted), 1);
        @(posedge clk); #1 en = 1'b0;
        repeat (10) @(posedge clk);
        finish_run();
    end
endmodule